// File: doc/BRIEF.md
# Forwarded-Clock Two-Lane Serial Link

This block is the transmit and receive side of a point-to-point serial link between two neighbouring logic devices. Each direction is a separate bus of three lanes: one carries a clock that the transmitter generates and the other two carry data. The transmitter takes 16-bit words on a valid/ready port, wraps each in a nine-slot frame and spreads the bits over the two data lanes. It drives the clock lane so that its rising edge falls in the middle of every data slot. When no word is waiting, it fills the line with synchronisation frames.

The receiver has no clock recovery. It captures both data lanes on the rising edge of the incoming clock lane and searches the bit stream for a synchronisation frame to find frame boundaries. It declares lock only after several correct synchronisation frames in a row. Payload words received while locked pass through a small dual-clock FIFO into the local clock domain and leave on a valid/ready port. The two sides share only the local clock and reset. A device instantiates one pair for each neighbour, with the transmit lanes of one end wired to the receive lanes of the other.

Top module: `fwdlink_pair`

## Requirements
- R1: The outgoing clock lane changes level on every local clock cycle, so one data slot lasts two local cycles. The data lanes change only on the cycle in which the clock lane goes from high to low, which places each rising clock-lane edge in the middle of a slot.
- R2: A frame lasts nine slots, and the header slot goes first. In the header, a data frame puts 1 on lane 0 and 0 on lane 1, and a sync frame puts 0 on lane 0 and 1 on lane 1. In slot k+1 (k = 0..7), payload bit 2k is on lane 0 and bit 2k+1 is on lane 1.
- R3: Whenever no accepted word is waiting at a frame start, the transmitter sends a sync frame. Its payload is the pattern 16'hB4C7.
- R4: tx_ready is high when the one-word holding slot is free. A word taken with tx_valid and tx_ready goes out in the next frame, and tx_ready stays low from the cycle after acceptance until that frame begins.
- R5: rx_locked rises only after 4 consecutive correct sync frames on one frame alignment. Any other frame seen during acquisition restarts the search.
- R6: Once locked, 2 consecutive bad frames drop the lock and restart the search. A bad frame has a header of 00 or 11, or a sync header with the wrong pattern. A single bad frame followed by a good one keeps the lock, and nothing is delivered while unlocked.
- R7: Every data frame received while locked delivers its payload unchanged and in order on rx_data.
- R8: With rx_ready held high, rx_valid is high for exactly one cycle per received word. While rx_valid is high and rx_ready is low, rx_valid and rx_data hold.
- R9: The receiver buffers 5 words: 4 in the FIFO and 1 in the output register. A word that arrives when the buffer is full is dropped, and rx_overflow goes high and stays high until reset.
- R10: After reset, tx_ready is 1 and rx_valid, rx_locked and rx_overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 16 | Word to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Holding slot free, word accepted when valid |
| lane_clk_o | output | 1 | Outgoing forwarded clock lane |
| lane_d_o | output | 2 | Outgoing data lanes |
| lane_clk_i | input | 1 | Incoming forwarded clock lane |
| lane_d_i | input | 2 | Incoming data lanes |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | rx_data holds a word |
| rx_ready | input | 1 | Consumer takes the word |
| rx_locked | output | 1 | Receiver is framed and locked |
| rx_overflow | output | 1 | Sticky flag, a word was dropped |

## Verification
The outgoing lanes are checked against expected frames for an idle line and for a single word, which tells a correct header, slot order and lane assignment apart from swapped or shifted ones. A stream through a looped-back link uses 16'hAAAA, 16'h5555, 16'h0001, 16'h8000, the sync pattern sent as payload, and 16'hFFFF. These words expose lane swaps and reversed bit order, and they show that a data header with sync content is still delivered. On the line, a one-slot glitch must keep the lock while a sustained stuck fault must lose it, and the receiver must then lock again. A receiver that is held off exercises the hold rule, and a longer held-off stream exercises the exact five-word drop point.

// File: rtl/fwdlink_pkg.sv
`timescale 1ns/1ps
package fwdlink_pkg;
  // Header slot, written as {lane1, lane0}
  localparam logic [1:0] HDR_DATA = 2'b01;
  localparam logic [1:0] HDR_SYNC = 2'b10;

  typedef enum logic [1:0] {FR_DATA, FR_SYNC, FR_BAD} frame_kind_e;
endpackage

// File: rtl/fwdlink_bit_sync.sv
`timescale 1ns/1ps
module fwdlink_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fwdlink_tx.sv
`timescale 1ns/1ps
module fwdlink_tx
  import fwdlink_pkg::*;
#(
  parameter int              WORD_W    = 16,
  parameter logic [WORD_W-1:0] SYNC_WORD = 16'hB4C7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              lane_clk_o,
  output logic [1:0]        lane_d_o
);
  localparam int SLOTS = WORD_W / 2 + 1;
  localparam int POS_W = $clog2(SLOTS);
  localparam logic [POS_W-1:0] LAST = POS_W'(SLOTS - 1);

  // Free-running from configuration so the far end can leave its own reset
  logic half = 1'b0;
  logic              pend;
  logic [WORD_W-1:0] pend_word;
  logic [POS_W-1:0]  slot;
  logic [SLOTS-1:0]  sh0, sh1, nf0, nf1;
  logic [WORD_W-1:0] src;

  assign src = pend ? pend_word : SYNC_WORD;

  always_comb begin
    nf0[0] = pend ? HDR_DATA[0] : HDR_SYNC[0];
    nf1[0] = pend ? HDR_DATA[1] : HDR_SYNC[1];
    for (int k = 0; k < WORD_W / 2; k++) begin
      nf0[k+1] = src[2*k];
      nf1[k+1] = src[2*k+1];
    end
  end

  always_ff @(posedge clk) half <= ~half;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_word <= '0;
      slot      <= LAST;
      sh0       <= '0;
      sh1       <= '0;
      lane_d_o  <= 2'b00;
    end else begin
      if (tx_valid && !pend) begin
        pend      <= 1'b1;
        pend_word <= tx_data;
      end
      if (half) begin
        if (slot == LAST) begin
          lane_d_o <= {nf1[0], nf0[0]};
          sh0      <= nf0 >> 1;
          sh1      <= nf1 >> 1;
          slot     <= '0;
          if (pend) pend <= 1'b0;
        end else begin
          lane_d_o <= {sh1[0], sh0[0]};
          sh0      <= sh0 >> 1;
          sh1      <= sh1 >> 1;
          slot     <= slot + 1'b1;
        end
      end
    end
  end

  assign tx_ready   = !pend;
  assign lane_clk_o = half;

  assert_clk_lane_toggles_R1: assert property (@(posedge clk) disable iff (rst)
    lane_clk_o != $past(lane_clk_o));
  assert_data_moves_on_fall_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(lane_d_o) |-> $fell(lane_clk_o));
  assert_ready_drops_after_take_R4: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> !tx_ready);
endmodule

// File: rtl/fwdlink_rx_framer.sv
`timescale 1ns/1ps
module fwdlink_rx_framer
  import fwdlink_pkg::*;
#(
  parameter int                WORD_W       = 16,
  parameter logic [WORD_W-1:0] SYNC_WORD    = 16'hB4C7,
  parameter int                LOCK_COUNT   = 4,
  parameter int                UNLOCK_COUNT = 2
) (
  input  logic              lane_clk,
  input  logic              lrst,
  input  logic [1:0]        lane_d,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              locked
);
  localparam int SLOTS = WORD_W / 2 + 1;
  localparam int POS_W = $clog2(SLOTS);
  localparam int GC_W  = $clog2(LOCK_COUNT + 1);
  localparam int BC_W  = $clog2(UNLOCK_COUNT + 1);

  logic [SLOTS-1:0]  win0, win1, nx0, nx1;
  logic [WORD_W-1:0] cand;
  frame_kind_e       kind;
  logic              aligned;
  logic [POS_W-1:0]  pos;
  logic [GC_W-1:0]   good;
  logic [BC_W-1:0]   bad;

  // Oldest slot sits at bit 0 once a full frame has shifted in
  assign nx0 = {lane_d[0], win0[SLOTS-1:1]};
  assign nx1 = {lane_d[1], win1[SLOTS-1:1]};

  for (genvar k = 0; k < WORD_W / 2; k++) begin : g_unstripe
    assign cand[2*k]   = nx0[k+1];
    assign cand[2*k+1] = nx1[k+1];
  end

  always_comb begin
    if ({nx1[0], nx0[0]} == HDR_DATA)
      kind = FR_DATA;
    else if ({nx1[0], nx0[0]} == HDR_SYNC && cand == SYNC_WORD)
      kind = FR_SYNC;
    else
      kind = FR_BAD;
  end

  always_ff @(posedge lane_clk) begin
    wr_en <= 1'b0;
    if (lrst) begin
      win0 <= '0; win1 <= '0;
      aligned <= 1'b0; locked <= 1'b0;
      pos <= '0; good <= '0; bad <= '0;
      wr_data <= '0;
    end else begin
      win0 <= nx0;
      win1 <= nx1;
      if (!aligned) begin
        if (kind == FR_SYNC) begin
          aligned <= 1'b1;
          pos     <= '0;
          good    <= GC_W'(1);
        end
      end else if (pos != POS_W'(SLOTS - 1)) begin
        pos <= pos + 1'b1;
      end else begin
        pos <= '0;
        if (!locked) begin
          if (kind == FR_SYNC) begin
            if (good == GC_W'(LOCK_COUNT - 1)) begin
              locked <= 1'b1;
              bad    <= '0;
            end else begin
              good <= good + 1'b1;
            end
          end else begin
            aligned <= 1'b0;
            good    <= '0;
          end
        end else begin
          case (kind)
            FR_DATA: begin
              wr_en   <= 1'b1;
              wr_data <= cand;
              bad     <= '0;
            end
            FR_SYNC: bad <= '0;
            default: begin
              if (bad == BC_W'(UNLOCK_COUNT - 1)) begin
                locked  <= 1'b0;
                aligned <= 1'b0;
                good    <= '0;
                bad     <= '0;
              end else begin
                bad <= bad + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  assert_push_only_locked_R6: assert property (@(posedge lane_clk) disable iff (lrst)
    wr_en |-> locked);
  assert_unlock_after_bad_run_R6: assert property (@(posedge lane_clk) disable iff (lrst)
    $fell(locked) |-> $past(bad) == BC_W'(UNLOCK_COUNT - 1));
  assert_lock_needs_good_run_R5: assert property (@(posedge lane_clk) disable iff (lrst)
    $rose(locked) |-> $past(good) == GC_W'(LOCK_COUNT - 1));
endmodule

// File: rtl/fwdlink_cdc_fifo.sv
`timescale 1ns/1ps
module fwdlink_cdc_fifo #(
  parameter int WIDTH = 16,
  parameter int AW    = 2
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wen,
  input  logic [WIDTH-1:0] wdata,
  output logic             ovf,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             rready,
  output logic             rvalid,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, wnext, rbin, rgray, rnext;
  logic [AW:0] rg_w1, rg_w2, wg_r1, wg_r2;
  logic        full, empty, pop;

  assign wnext = wbin + 1'b1;
  assign rnext = rbin + 1'b1;
  assign full  = (wgray == {~rg_w2[AW:AW-1], rg_w2[AW-2:0]});
  assign empty = (rgray == wg_r2);
  assign pop   = !empty && (!rvalid || rready);

  always_ff @(posedge wclk) begin
    if (wen && !full) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin <= '0; wgray <= '0; ovf <= 1'b0;
      rg_w1 <= '0; rg_w2 <= '0;
    end else begin
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      if (wen) begin
        if (full) begin
          ovf <= 1'b1;
        end else begin
          wbin  <= wnext;
          wgray <= (wnext >> 1) ^ wnext;
        end
      end
    end
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin <= '0; rgray <= '0;
      wg_r1 <= '0; wg_r2 <= '0;
      rvalid <= 1'b0; rdata <= '0;
    end else begin
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      if (pop) begin
        rdata  <= mem[rbin[AW-1:0]];
        rvalid <= 1'b1;
        rbin   <= rnext;
        rgray  <= (rnext >> 1) ^ rnext;
      end else if (rready) begin
        rvalid <= 1'b0;
      end
    end
  end

  assert_hold_while_stalled_R8: assert property (@(posedge rclk) disable iff (rrst)
    rvalid && !rready |=> rvalid && $stable(rdata));
  assert_overflow_sticky_R9: assert property (@(posedge wclk) disable iff (wrst)
    ovf |=> ovf);
endmodule

// File: rtl/fwdlink_pair.sv
`timescale 1ns/1ps
module fwdlink_pair #(
  parameter int                WORD_W       = 16,
  parameter logic [WORD_W-1:0] SYNC_WORD    = 16'hB4C7,
  parameter int                LOCK_COUNT   = 4,
  parameter int                UNLOCK_COUNT = 2,
  parameter int                FIFO_AW      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              lane_clk_o,
  output logic [1:0]        lane_d_o,
  input  logic              lane_clk_i,
  input  logic [1:0]        lane_d_i,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_locked,
  output logic              rx_overflow
);
  // Reset carried into the incoming clock-lane domain
  logic [1:0] lrst_q = 2'b11;
  logic              lrst;
  logic              wr_en, lock_l, ovf_l;
  logic [WORD_W-1:0] wr_data;

  always_ff @(posedge lane_clk_i) lrst_q <= {lrst_q[0], rst};
  assign lrst = lrst_q[1];

  fwdlink_tx #(.WORD_W(WORD_W), .SYNC_WORD(SYNC_WORD)) u_tx (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .lane_clk_o(lane_clk_o), .lane_d_o(lane_d_o)
  );

  fwdlink_rx_framer #(
    .WORD_W(WORD_W), .SYNC_WORD(SYNC_WORD),
    .LOCK_COUNT(LOCK_COUNT), .UNLOCK_COUNT(UNLOCK_COUNT)
  ) u_framer (
    .lane_clk(lane_clk_i), .lrst(lrst), .lane_d(lane_d_i),
    .wr_en(wr_en), .wr_data(wr_data), .locked(lock_l)
  );

  fwdlink_cdc_fifo #(.WIDTH(WORD_W), .AW(FIFO_AW)) u_fifo (
    .wclk(lane_clk_i), .wrst(lrst), .wen(wr_en), .wdata(wr_data), .ovf(ovf_l),
    .rclk(clk), .rrst(rst), .rready(rx_ready), .rvalid(rx_valid), .rdata(rx_data)
  );

  fwdlink_bit_sync #(.STAGES(2)) u_sync_lock (
    .clk(clk), .rst(rst), .d(lock_l), .q(rx_locked)
  );

  fwdlink_bit_sync #(.STAGES(2)) u_sync_ovf (
    .clk(clk), .rst(rst), .d(ovf_l), .q(rx_overflow)
  );
endmodule

// File: tb/fwdlink_pair_test.sv
`timescale 1ns/1ps
module fwdlink_pair_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, lane_clk_o;
  logic [1:0]  lane_d_o;
  logic [15:0] rx_data;
  logic        rx_valid, rx_locked, rx_overflow;
  logic        rx_ready = 1'b1;
  logic        stuck = 1'b0;
  logic [1:0]  flip = 2'b00;
  logic        lane_clk_i;
  logic [1:0]  lane_d_i;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  // Loopback with fault injection on the data lanes
  assign lane_clk_i = lane_clk_o;
  assign lane_d_i   = stuck ? 2'b11 : (lane_d_o ^ flip);

  fwdlink_pair uut (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .lane_clk_o(lane_clk_o), .lane_d_o(lane_d_o), .lane_clk_i(lane_clk_i), .lane_d_i(lane_d_i),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_locked(rx_locked), .rx_overflow(rx_overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Line-side observer of the outgoing lanes
  logic [8:0] m0 = '0, m1 = '0;
  logic       m_prev = 1'b0;
  always @(negedge clk) begin
    if (lane_clk_o && !m_prev) begin
      m0 <= {lane_d_o[0], m0[8:1]};
      m1 <= {lane_d_o[1], m1[8:1]};
    end
    m_prev <= lane_clk_o;
  end

  // Timing rule R1 watcher
  int   r1_err = 0;
  logic p_ok = 1'b0, p_clk = 1'b0;
  logic [1:0] p_d = '0;
  always @(negedge clk) begin
    if (!rst && p_ok) begin
      if (lane_clk_o == p_clk) r1_err++;
      if (lane_d_o != p_d && !(p_clk && !lane_clk_o)) r1_err++;
    end
    p_ok  <= !rst;
    p_clk <= lane_clk_o;
    p_d   <= lane_d_o;
  end

  // Receive collector
  logic [15:0] rxq [64];
  int rx_n = 0;
  always @(negedge clk) begin
    if (!rst && rx_valid && rx_ready && rx_n < 64) begin
      rxq[rx_n] = rx_data;
      rx_n++;
    end
  end

  function automatic logic [17:0] exp_frame(input bit is_data, input logic [15:0] w);
    logic [8:0] a, b;
    a[0] = is_data;
    b[0] = !is_data;
    for (int k = 0; k < 8; k++) begin
      a[k+1] = w[2*k];
      b[k+1] = w[2*k+1];
    end
    return {b, a};
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic send_word(input logic [15:0] w);
    int t = 0;
    @(posedge clk); #1;
    while (!tx_ready && t < 1000) begin @(posedge clk); #1; t++; end
    tx_data = w; tx_valid = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic wait_frame(input logic [17:0] exp, input int max, output bit found);
    found = 1'b0;
    for (int i = 0; i < max && !found; i++) begin
      @(negedge clk); #1;
      if ({m1, m0} == exp) found = 1'b1;
    end
  endtask

  task automatic wait_lock(input int max, output int took);
    took = -1;
    for (int i = 0; i < max && took < 0; i++) begin
      @(negedge clk);
      if (rx_locked) took = i;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; tx_valid = 1'b0; rx_ready = 1'b1; stuck = 1'b0; flip = 2'b00;
    cycles(10);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(tx_ready == 1'b1, "R10 tx_ready", tx_ready, 1);
    chk({rx_valid, rx_locked, rx_overflow} == 3'b000, "R10 rx flags",
        {rx_valid, rx_locked, rx_overflow}, 0);
  endtask

  task automatic t_lock_timing();
    int took;
    do_reset();
    cycles(50);
    @(negedge clk);
    chk(rx_locked == 1'b0, "R5 no lock before four sync frames", rx_locked, 0);
    wait_lock(400, took);
    chk(took >= 0, "R5 lock reached", took, 1);
  endtask

  task automatic t_idle_sync();
    bit f;
    wait_frame(exp_frame(1'b0, 16'hB4C7), 60, f);
    chk(f, "R3 idle sync frame on line", {m1, m0}, exp_frame(1'b0, 16'hB4C7));
    cycles(100);
    chk(r1_err == 0, "R1 clock lane and slot timing", r1_err, 0);
  endtask

  task automatic t_one_word();
    bit f;
    send_word(16'h1234);
    @(negedge clk);
    chk(tx_ready == 1'b0, "R4 ready low after accept", tx_ready, 0);
    wait_frame(exp_frame(1'b1, 16'h1234), 80, f);
    chk(f, "R2 data frame layout", {m1, m0}, exp_frame(1'b1, 16'h1234));
    @(negedge clk);
    chk(tx_ready == 1'b1, "R4 ready back after frame start", tx_ready, 1);
    cycles(60);
  endtask

  task automatic t_stream();
    logic [15:0] w [6] = '{16'hAAAA, 16'h5555, 16'h0001, 16'h8000, 16'hB4C7, 16'hFFFF};
    rx_n = 0;
    for (int i = 0; i < 6; i++) send_word(w[i]);
    cycles(120);
    chk(rx_n == 6, "R8 one valid cycle per word", rx_n, 6);
    for (int i = 0; i < 6; i++)
      chk(rxq[i] == w[i], "R7 word delivered in order", rxq[i], w[i]);
  endtask

  task automatic t_hold();
    bit ok = 1'b1;
    rx_ready = 1'b0;
    rx_n = 0;
    send_word(16'hC0DE);
    cycles(80);
    @(negedge clk);
    chk(rx_valid && rx_data == 16'hC0DE, "R8 word presented", rx_data, 16'hC0DE);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!rx_valid || rx_data != 16'hC0DE) ok = 1'b0;
    end
    chk(ok, "R8 hold while not ready", rx_data, 16'hC0DE);
    @(posedge clk); #1;
    rx_ready = 1'b1;
    cycles(3);
    @(negedge clk);
    chk(!rx_valid && rx_n == 1, "R8 single transfer after release", rx_n, 1);
  endtask

  task automatic t_glitch();
    rx_n = 0;
    @(negedge clk);
    flip = 2'b01;
    @(negedge clk); @(negedge clk);
    flip = 2'b00;
    cycles(100);
    @(negedge clk);
    chk(rx_locked == 1'b1, "R6 lock kept over one bad frame", rx_locked, 1);
    chk(rx_n == 0, "R6 no spurious word from glitch", rx_n, 0);
  endtask

  task automatic t_lose_lock();
    int took;
    rx_n = 0;
    @(posedge clk); #1;
    stuck = 1'b1;
    cycles(60);
    @(negedge clk);
    chk(rx_locked == 1'b0, "R6 lock lost on sustained fault", rx_locked, 0);
    send_word(16'h0BAD);
    cycles(20);
    chk(rx_n == 0, "R6 nothing delivered unlocked", rx_n, 0);
    stuck = 1'b0;
    wait_lock(600, took);
    chk(took >= 0, "R5 relock after fault", took, 1);
    cycles(60);
  endtask

  task automatic t_overflow();
    rx_ready = 1'b0;
    rx_n = 0;
    for (int i = 0; i < 7; i++) send_word(16'h0100 + 16'(i));
    cycles(100);
    @(negedge clk);
    chk(rx_overflow == 1'b1, "R9 overflow flagged", rx_overflow, 1);
    @(posedge clk); #1;
    rx_ready = 1'b1;
    cycles(40);
    chk(rx_n == 5, "R9 five words kept", rx_n, 5);
    for (int i = 0; i < 5; i++)
      chk(rxq[i] == 16'h0100 + 16'(i), "R9 oldest words kept", rxq[i], 16'h0100 + 16'(i));
    @(negedge clk);
    chk(rx_overflow == 1'b1, "R9 flag sticky", rx_overflow, 1);
  endtask

  initial begin
    t_reset();
    t_lock_timing();
    t_idle_sync();
    t_one_word();
    t_stream();
    t_hold();
    t_glitch();
    t_lose_lock();
    t_overflow();
    t_reset();
    chk(r1_err == 0, "R1 timing over whole run", r1_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule